// File: doc/BRIEF.md
# Card Reset and Power-Good Sequencer

This block decides when a hot-pluggable card slot may leave reset. It watches per-rail "within tolerance" flags from external comparators, a power-on indication from the slot mode controller, an active-low warm reset from the host, and the sensed level of a shared open-drain reference-clock-enable line. It drives two outputs: the active-low card reset and a pull-down enable for the shared line. While the shared line is pulled low, it tells the host that card power is not good.

The shared line is pulled low whenever the slot is unpowered or a rail is out of tolerance, and it is released once every rail is good. When the line is seen to rise, a release delay starts, and the card reset goes high when that delay ends. The host, or any other agent, can hold the line low to postpone the delay. A rail fault or a warm reset pulls the card reset low at once. Every reset pulse then lasts at least a minimum width, and it ends only after a fresh full release delay.

The controller has four states. `ST_HOLD_MIN` keeps the reset low until the minimum-width timer expires. `ST_AWAIT_CLK` keeps it low until a rising edge has been seen on the line while power is good and no warm reset is active. `ST_COUNT_DLY` runs the release delay. `ST_RELEASED` holds the reset high.

The transitions are these:
- hold-expire: `ST_HOLD_MIN` to `ST_AWAIT_CLK`.
- edge-start: `ST_AWAIT_CLK` to `ST_COUNT_DLY`, which loads the release delay.
- delay-done: `ST_COUNT_DLY` to `ST_RELEASED`.
- abort: `ST_COUNT_DLY` to `ST_HOLD_MIN`, taken on a rail fault, a warm reset or the line going low.
- drop: `ST_RELEASED` to `ST_HOLD_MIN`, taken on the same causes.

Both abort and drop reload the minimum-width timer. Cycle counts come from the timer clock rate and the two times given in microseconds.

Top module: `card_rst_seq`

## Requirements
- R1: During and right after block reset, `card_rst_n` is 0 and `refclk_pd` is 1.
- R2: `refclk_pd` is 1 while `slot_on` is 0 or any bit of `rail_ok` is 0. It goes to 0 on the clock edge after all rails are good with `slot_on` at 1.
- R3: `card_rst_n` rises only through the delay state. That happens no earlier than REL_CNT cycles and no later than REL_CNT+6 cycles after the sensed line rises with power good. It rises only if power was good in the cycle before.
- R4: `host_rst_n` at 0 passes through a two-flop synchronizer and forces `card_rst_n` to 0 within three clock edges.
- R5: A rail flag at 0 while the slot is on drives `card_rst_n` to 0 on the next clock edge.
- R6: Every low period of `card_rst_n` lasts at least MIN_CNT cycles, whatever its cause.
- R7: `refclk_pd` is never 0 later than `card_rst_n` goes to 0, so `card_rst_n`=1 implies `refclk_pd`=0.
- R8: With `slot_on` at 0, `card_rst_n` is 0 and `refclk_pd` is 1 on the next edge, regardless of `host_rst_n`.
- R9: A warm reset on `host_rst_n` leaves `refclk_pd` unchanged at 0 while power is good.
- R10: While an external agent holds `refclk_pin` low, the release delay does not start. Holding it low after release forces `card_rst_n` back to 0.
- R11: A rail fault or a low line during the release delay aborts it. A later release then needs the minimum width and a full new delay.
- R12: After a warm reset ends, `card_rst_n` rises only after the minimum width and a full release delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and state clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| rail_ok | input | NUM_RAILS | Per-rail within-tolerance flags, synchronous to clk |
| slot_on | input | 1 | Slot powered indication from the mode controller, synchronous |
| host_rst_n | input | 1 | Host warm reset, active low, asynchronous |
| refclk_pin | input | 1 | Sensed level of the shared open-drain clock-enable line |
| card_rst_n | output | 1 | Card reset, active low |
| refclk_pd | output | 1 | Pull-down enable for the shared line (1 = drive low) |

## Verification
The properties assume that `rail_ok` and `slot_on` are already synchronous to `clk` and free of glitches, since only `host_rst_n` and `refclk_pin` are synchronized inside. They also assume that the warm reset is not already low when block reset is released. The stimulus changes every input on the falling clock edge. It models the shared line as a pull-up that is low whenever the block or the bench pulls it down. Warm reset is applied only well after block reset.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        ST_HOLD_MIN  = 2'd0,
        ST_AWAIT_CLK = 2'd1,
        ST_COUNT_DLY = 2'd2,
        ST_RELEASED  = 2'd3
    } crs_state_e;

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/crs_timer.sv
module crs_timer #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    assign done = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= RST_VAL;
        else if (load)  cnt_q <= load_val;
        else if (!done) cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/crs_rise_latch.sv
module crs_rise_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic clear,
    output logic seen
);

    logic prev_q;
    logic seen_q;
    logic rise;

    assign rise = level & ~prev_q;
    assign seen = seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (clear || !level)  seen_q <= 1'b0;
        else if (rise)             seen_q <= 1'b1;
    end

endmodule

// File: rtl/card_rst_seq.sv
module card_rst_seq #(
    parameter int NUM_RAILS     = 3,
    parameter int TIMER_CLK_KHZ = 200000,
    parameter int REL_DELAY_US  = 2000,
    parameter int MIN_ASSERT_US = 150,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 slot_on,
    input  logic                 host_rst_n,
    input  logic                 refclk_pin,
    output logic                 card_rst_n,
    output logic                 refclk_pd
);
    import crs_pkg::*;

    localparam int REL_CNT = (TIMER_CLK_KHZ * REL_DELAY_US) / 1000;
    localparam int MIN_CNT = (TIMER_CLK_KHZ * MIN_ASSERT_US) / 1000;
    localparam int MAX_CNT = (REL_CNT > MIN_CNT) ? REL_CNT : MIN_CNT;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] REL_V = CNT_W'(REL_CNT);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);

    crs_state_e state_q, state_d;

    logic             host_rst_s;
    logic             refclk_s;
    logic             pwr_good;
    logic             fault;
    logic             rise_seen;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             card_rst_q;
    logic             pd_q;

    crs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_host_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (host_rst_n),
        .q     (host_rst_s)
    );

    crs_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (refclk_pin),
        .q     (refclk_s)
    );

    assign pwr_good = slot_on & (&rail_ok);
    assign fault    = ~pwr_good | ~host_rst_s;

    crs_rise_latch u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (refclk_s),
        .clear (~pwr_good),
        .seen  (rise_seen)
    );

    crs_timer #(.W(CNT_W), .RST_VAL(MIN_V)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // next-state logic and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = MIN_V;
        unique case (state_q)
            ST_HOLD_MIN: begin
                if (tmr_done) state_d = ST_AWAIT_CLK;
            end
            ST_AWAIT_CLK: begin
                if (!fault && rise_seen) begin
                    state_d  = ST_COUNT_DLY;
                    tmr_load = 1'b1;
                    tmr_val  = REL_V;
                end
            end
            ST_COUNT_DLY: begin
                if (fault || !refclk_s) begin
                    state_d  = ST_HOLD_MIN;
                    tmr_load = 1'b1;
                    tmr_val  = MIN_V;
                end else if (tmr_done) begin
                    state_d = ST_RELEASED;
                end
            end
            ST_RELEASED: begin
                if (fault || !refclk_s) begin
                    state_d  = ST_HOLD_MIN;
                    tmr_load = 1'b1;
                    tmr_val  = MIN_V;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD_MIN;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            card_rst_q <= 1'b0;
            pd_q       <= 1'b1;
        end else begin
            card_rst_q <= (state_d == ST_RELEASED);
            pd_q       <= ~pwr_good;
        end
    end

    assign card_rst_n = card_rst_q;
    assign refclk_pd  = pd_q;

endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
    parameter int NUM_RAILS = 3,
    parameter int MIN_CNT   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] rail_ok,
    input logic                 slot_on,
    input logic                 host_rst_n,
    input logic                 refclk_pin,
    input logic                 card_rst_n,
    input logic                 refclk_pd
);

    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_cnt <= '0;
        else if (card_rst_n) low_cnt <= '0;
        else if (low_cnt != 32'hFFFF_FFFF) low_cnt <= low_cnt + 1'b1;
    end

    assert_release_pd_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n |-> !refclk_pd);

    assert_rail_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_on && !(&rail_ok)) |=> (!card_rst_n && refclk_pd));

    assert_slot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_on |=> (!card_rst_n && refclk_pd));

    assert_warm_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !host_rst_n && $past(!host_rst_n)) |=> ##1 !card_rst_n);

    assert_warm_keeps_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rst_n && slot_on && (&rail_ok)) |=> !refclk_pd);

    assert_min_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> (low_cnt >= MIN_CNT));

    assert_release_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> $past(slot_on && (&rail_ok)));

    // refclk_pin is observed only by the bench model; keep it an input for traceability
    logic pin_seen;
    assign pin_seen = refclk_pin;
    always_comb begin
        assert_pin_known_R10: assert (!rst_n || pin_seen == 1'b0 || pin_seen == 1'b1);
    end

endmodule

bind card_rst_seq crs_checker #(.NUM_RAILS(NUM_RAILS), .MIN_CNT(MIN_CNT)) u_crs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rail_ok    (rail_ok),
    .slot_on    (slot_on),
    .host_rst_n (host_rst_n),
    .refclk_pin (refclk_pin),
    .card_rst_n (card_rst_n),
    .refclk_pd  (refclk_pd)
);

// File: tb/card_rst_seq_bench.sv
module card_rst_seq_bench;

    localparam int NR    = 3;
    localparam int KHZ   = 10;
    localparam int REL_U = 3000;   // 30 cycles
    localparam int MIN_U = 4000;   // 40 cycles

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_ok = '0;
    logic          slot_on = 1'b0;
    logic          host_rst_n = 1'b1;
    logic          ext_hold = 1'b0;
    logic          refclk_pin;
    logic          card_rst_n;
    logic          refclk_pd;

    assign refclk_pin = !(refclk_pd || ext_hold);

    always #2.5 clk = ~clk;

    card_rst_seq #(
        .NUM_RAILS(NR), .TIMER_CLK_KHZ(KHZ),
        .REL_DELAY_US(REL_U), .MIN_ASSERT_US(MIN_U), .SYNC_STAGES(2)
    ) u_card_rst_seq (
        .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .slot_on(slot_on),
        .host_rst_n(host_rst_n), .refclk_pin(refclk_pin),
        .card_rst_n(card_rst_n), .refclk_pd(refclk_pd)
    );

    typedef struct {
        int    at;
        bit    chk_rst;
        bit    rst_v;
        bit    chk_pd;
        bit    pd_v;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    // driver side: push expectation k posedges from now, sorted by time
    task automatic expect_at(input int k, input bit cr, input bit rv,
                             input bit cp, input bit pv, input string tag);
        exp_t e;
        int   idx;
        e.at = cyc + k; e.chk_rst = cr; e.rst_v = rv;
        e.chk_pd = cp; e.pd_v = pv; e.tag = tag;
        idx = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].at > e.at) begin idx = i; break; end
        end
        q.insert(idx, e);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (q.size() > 0 && q[0].at <= cyc) begin
                exp_t e;
                bit   ok;
                e  = q.pop_front();
                ok = 1'b1;
                if (e.chk_rst && card_rst_n !== e.rst_v) ok = 1'b0;
                if (e.chk_pd && refclk_pd !== e.pd_v) ok = 1'b0;
                total++;
                if (!ok) begin
                    bad++;
                    $display("FAIL %s cycle %0d: card_rst_n=%0b refclk_pd=%0b expected %0b/%0b",
                             e.tag, cyc, card_rst_n, refclk_pd, e.rst_v, e.pd_v);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        ticks(5);
        rst_n = 1'b1;
        expect_at(1, 1, 0, 1, 1, "R1 reset state");
        ticks(3);

        // R8 slot off with rails good
        rail_ok = '1;
        expect_at(3, 1, 0, 1, 1, "R8 off mode early");
        expect_at(60, 1, 0, 1, 1, "R8 off mode late");
        ticks(70);

        // R2 / R3 power up
        slot_on = 1'b1;
        expect_at(3, 1, 0, 1, 0, "R2 pd released");
        expect_at(33, 1, 0, 0, 0, "R3 not before delay");
        expect_at(40, 1, 1, 1, 0, "R3 released after delay");
        ticks(50);

        // R4 / R9 / R6 / R12 warm reset
        host_rst_n = 1'b0;
        expect_at(5, 1, 0, 1, 0, "R4 warm reset asserts");
        expect_at(60, 1, 0, 0, 0, "R6 min width after warm reset");
        expect_at(68, 0, 0, 1, 0, "R9 pd untouched by warm reset");
        expect_at(85, 1, 1, 0, 0, "R12 release after warm reset");
        ticks(6);
        host_rst_n = 1'b1;
        ticks(89);

        // R5 / R7 rail fault
        rail_ok[1] = 1'b0;
        expect_at(1, 1, 0, 1, 1, "R7 pd with reset same edge");
        expect_at(2, 1, 0, 1, 1, "R5 rail fault");
        expect_at(60, 1, 0, 1, 0, "R6 min width after fault");
        expect_at(82, 1, 1, 0, 0, "R2 recovery release");
        ticks(3);
        rail_ok[1] = 1'b1;
        ticks(87);

        // R10 external hold
        ext_hold = 1'b1;
        expect_at(5, 1, 0, 1, 0, "R10 hold forces reset");
        expect_at(79, 1, 0, 0, 0, "R10 timer held off");
        expect_at(110, 1, 0, 0, 0, "R10 delay after hold release");
        expect_at(122, 1, 1, 0, 0, "R10 release after hold");
        ticks(80);
        ext_hold = 1'b0;
        ticks(50);

        // R11 abort by line going low mid-delay
        ext_hold = 1'b1;
        expect_at(90, 1, 0, 0, 0, "R11 aborted delay");
        expect_at(135, 1, 0, 0, 0, "R11 full new delay");
        expect_at(148, 1, 1, 0, 0, "R11 release after abort");
        ticks(50);
        ext_hold = 1'b0;
        ticks(15);
        ext_hold = 1'b1;
        ticks(5);
        ext_hold = 1'b0;
        ticks(90);

        // R8 standby regardless of warm reset
        slot_on = 1'b0;
        host_rst_n = 1'b0;
        expect_at(2, 1, 0, 1, 1, "R8 standby");
        expect_at(40, 1, 0, 1, 1, "R8 standby held");
        ticks(20);
        host_rst_n = 1'b1;
        ticks(30);

        // R11 abort by rail fault mid-delay
        slot_on = 1'b1;
        expect_at(17, 1, 0, 1, 1, "R11 rail fault during delay");
        expect_at(45, 1, 0, 1, 0, "R11 no early release");
        expect_at(95, 1, 1, 1, 0, "R11 release after rail abort");
        ticks(15);
        rail_ok[0] = 1'b0;
        ticks(2);
        rail_ok[0] = 1'b1;
        ticks(90);

        while (q.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule